// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Register

This block holds the interrupt flags of a clock-controller peripheral. It watches a 32-bit vector of live status levels from the oscillators and loops. For each implemented bit, a chosen edge of that level latches a sticky flag. Software reads the flags over a simple register bus and clears them by writing ones. A separate enable vector is set and cleared through two write-one registers. Each flag is ANDed with its enable, the results are ORed, and that single OR drives one registered interrupt request.

Only ten bit positions carry flags. All of them latch on a low-to-high status edge except bit 19, which latches on a high-to-low edge. Every status bit passes through one sampling register. The edge is found by comparing that sample with the one before it. A flag therefore shows on the bus two clock edges after the status change is first sampled, and the interrupt request follows one edge later.

Top module: `irq_flag_reg`

## Requirements
- R1: While reset is held and just after it, the flags, the enables and `irq_o` are all zero, and every register reads zero.
- R2: The implemented bit mask is 0x000F0713 (bits 0, 1, 4, 8, 9, 10, 16, 17, 18, 19). Other bits always read zero, and writes to them have no effect. Addresses other than 0x04, 0x08 and 0x0C read zero.
- R3: For every implemented bit except bit 19, a 0-to-1 change of `status_i` sets that flag. A change first sampled at clock edge k is visible on the flag register (offset 0x0C) after edge k+1.
- R4: Bit 19 sets on a 1-to-0 change of `status_i[19]` with the same timing as R3. A 0-to-1 change of bit 19 sets nothing.
- R5: A write to offset 0x0C clears every flag whose `wdata_i` bit is 1.
- R6: Flag bits written with 0 keep their value.
- R7: If a set edge and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: A status level that stays constant does not set a flag again after the flag has been cleared.
- R9: A write of ones to offset 0x08 sets enable bits, and a write of ones to offset 0x04 clears them. Both offsets read back the current enable vector, limited to the R2 mask.
- R10: `irq_o` is a register that holds the OR over all bits of flag AND enable, one cycle late. It stays low while no set flag is enabled, and it drops one edge after the last enabled flag is cleared.
- R11: The edge history resets to zero. A status bit that is already high when reset is released sets its rising-edge flag on the first sampled cycle. Bit 19 held high through reset sets nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register, combinational |
| status_i | input | 32 | Live status levels from the clock sources |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives pairs of status vectors. Each pair mixes rising and falling edges over implemented and unimplemented bits. A design with the wrong polarity on bit 19, or with flags on unimplemented bits, returns the wrong flag word. A write-1 clear is placed in the same cycle as a new edge: a design where the clear wins loses the event. A level is kept steady after a clear: a level-sensitive design sets the flag again. The bench checks `irq_o` one edge after an enable is set and one edge after the flag is cleared. Bit 0 is held high through reset: history registers that reset to the input value, or no history reset at all, miss that flag.

// File: rtl/irqflag_pkg.sv
package irqflag_pkg;

    localparam int          DATA_W     = 32;
    localparam int          ADDR_W     = 8;
    localparam logic [31:0] DEF_IMPL   = 32'h000F_0713;
    localparam logic [31:0] DEF_FALL   = 32'h0008_0000;
    localparam logic [7:0]  DEF_ENCLR  = 8'h04;
    localparam logic [7:0]  DEF_ENSET  = 8'h08;
    localparam logic [7:0]  DEF_FLAG   = 8'h0C;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ENCLR,
        SEL_ENSET,
        SEL_FLAG
    } reg_sel_e;

endpackage

// File: rtl/irqflag_edge.sv
module irqflag_edge #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1,
    parameter logic [W-1:0] FALL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] status_i,
    output logic [W-1:0] event_o
);

    logic [W-1:0] samp_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] raw;

    // one sampling stage, one history stage
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            samp_q <= '0;
            prev_q <= '0;
        end else begin
            samp_q <= status_i;
            prev_q <= samp_q;
        end
    end

    // per-bit polarity picked by the FALL mask
    generate
        for (genvar i = 0; i < W; i++) begin : g_pol
            if (FALL[i]) begin : g_fall
                assign raw[i] = prev_q[i] & ~samp_q[i];
            end else begin : g_rise
                assign raw[i] = samp_q[i] & ~prev_q[i];
            end
        end
    endgenerate

    assign event_o = raw & IMPL;

endmodule

// File: rtl/irqflag_bank.sv
module irqflag_bank #(
    parameter int           W        = 32,
    parameter logic [W-1:0] IMPL     = '1,
    parameter bit           SET_WINS = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] bits_o
);

    logic [W-1:0] bits_q;
    logic [W-1:0] bits_nxt;

    generate
        if (SET_WINS) begin : g_set_first
            assign bits_nxt = (bits_q & ~clr_i) | set_i;
        end else begin : g_clr_first
            assign bits_nxt = (bits_q | set_i) & ~clr_i;
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_nxt & IMPL;
        end
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/irqflag_decode.sv
module irqflag_decode
    import irqflag_pkg::*;
#(
    parameter int                AW        = 8,
    parameter logic [AW-1:0]     OFF_ENCLR = 8'h04,
    parameter logic [AW-1:0]     OFF_ENSET = 8'h08,
    parameter logic [AW-1:0]     OFF_FLAG  = 8'h0C
) (
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    output reg_sel_e      sel_o,
    output logic          wr_flag_o,
    output logic          wr_enset_o,
    output logic          wr_enclr_o
);

    always_comb begin
        if (addr_i == OFF_FLAG) begin
            sel_o = SEL_FLAG;
        end else if (addr_i == OFF_ENSET) begin
            sel_o = SEL_ENSET;
        end else if (addr_i == OFF_ENCLR) begin
            sel_o = SEL_ENCLR;
        end else begin
            sel_o = SEL_NONE;
        end
    end

    assign wr_flag_o  = wr_en_i && (sel_o == SEL_FLAG);
    assign wr_enset_o = wr_en_i && (sel_o == SEL_ENSET);
    assign wr_enclr_o = wr_en_i && (sel_o == SEL_ENCLR);

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irqflag_pkg::*;
#(
    parameter int                W         = DATA_W,
    parameter int                AW        = ADDR_W,
    parameter logic [W-1:0]      IMPL      = DEF_IMPL,
    parameter logic [W-1:0]      FALL      = DEF_FALL,
    parameter logic [AW-1:0]     OFF_ENCLR = DEF_ENCLR,
    parameter logic [AW-1:0]     OFF_ENSET = DEF_ENSET,
    parameter logic [AW-1:0]     OFF_FLAG  = DEF_FLAG
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    input  logic [W-1:0]  status_i,
    output logic          irq_o
);

    reg_sel_e     sel;
    logic         wr_flag;
    logic         wr_enset;
    logic         wr_enclr;
    logic [W-1:0] edge_ev;
    logic [W-1:0] flag_q;
    logic [W-1:0] en_q;
    logic         irq_q;

    irqflag_decode #(
        .AW        (AW),
        .OFF_ENCLR (OFF_ENCLR),
        .OFF_ENSET (OFF_ENSET),
        .OFF_FLAG  (OFF_FLAG)
    ) u_dec (
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .sel_o      (sel),
        .wr_flag_o  (wr_flag),
        .wr_enset_o (wr_enset),
        .wr_enclr_o (wr_enclr)
    );

    irqflag_edge #(
        .W    (W),
        .IMPL (IMPL),
        .FALL (FALL)
    ) u_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .status_i (status_i),
        .event_o  (edge_ev)
    );

    // flags: a new edge beats a same-cycle clear
    irqflag_bank #(
        .W        (W),
        .IMPL     (IMPL),
        .SET_WINS (1'b1)
    ) u_flags (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (edge_ev),
        .clr_i  (wr_flag ? wdata_i : '0),
        .bits_o (flag_q)
    );

    // enables: set and clear come from separate addresses
    irqflag_bank #(
        .W        (W),
        .IMPL     (IMPL),
        .SET_WINS (1'b0)
    ) u_enables (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (wr_enset ? wdata_i : '0),
        .clr_i  (wr_enclr ? wdata_i : '0),
        .bits_o (en_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(flag_q & en_q);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAG:  rdata_o = flag_q;
            SEL_ENSET: rdata_o = en_q;
            SEL_ENCLR: rdata_o = en_q;
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk
    import irqflag_pkg::*;
#(
    parameter int            W         = DATA_W,
    parameter int            AW        = ADDR_W,
    parameter logic [W-1:0]  IMPL      = DEF_IMPL,
    parameter logic [W-1:0]  FALL      = DEF_FALL,
    parameter logic [AW-1:0] OFF_ENCLR = DEF_ENCLR,
    parameter logic [AW-1:0] OFF_ENSET = DEF_ENSET,
    parameter logic [AW-1:0] OFF_FLAG  = DEF_FLAG
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [AW-1:0] addr_i,
    input logic          wr_en_i,
    input logic [W-1:0]  wdata_i,
    input logic [W-1:0]  rdata_o,
    input logic [W-1:0]  status_i,
    input logic          irq_o,
    input logic [W-1:0]  flag_q,
    input logic [W-1:0]  en_q
);

    logic [W-1:0] st_d;
    logic [W-1:0] rise_v;
    logic [W-1:0] fall_v;
    logic [W-1:0] flag_clr;
    logic         known_addr;

    always_ff @(posedge clk_i) begin
        if (rst_i) st_d <= '0;
        else       st_d <= status_i;
    end

    assign rise_v     = status_i & ~st_d & IMPL & ~FALL;
    assign fall_v     = ~status_i & st_d & IMPL & FALL;
    assign flag_clr   = (wr_en_i && addr_i == OFF_FLAG) ? wdata_i : '0;
    assign known_addr = (addr_i == OFF_FLAG) || (addr_i == OFF_ENSET) || (addr_i == OFF_ENCLR);

    p_unimpl_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdata_o & ~IMPL) == '0);

    p_other_addr_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !known_addr |-> rdata_o == '0);

    p_rise_sets_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_v != '0) |=> ##1 ((flag_q & $past(rise_v, 2)) == $past(rise_v, 2)));

    p_fall_sets_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (fall_v != '0) |=> ##1 ((flag_q & $past(fall_v, 2)) == $past(fall_v, 2)));

    // R5 and R6: only flags written with 1 may drop
    p_keep_unwritten_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> ((flag_q & $past(flag_q & ~flag_clr)) == $past(flag_q & ~flag_clr)));

    p_enset_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == OFF_ENSET) |=> ((en_q & $past(wdata_i & IMPL)) == $past(wdata_i & IMPL)));

    p_enclr_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == OFF_ENCLR) |=> ((en_q & $past(wdata_i)) == '0));

    p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_q == '0) |=> !irq_o);

    p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> $past(flag_q) != '0);

endmodule

bind irq_flag_reg irq_flag_reg_chk #(
    .W         (W),
    .AW        (AW),
    .IMPL      (IMPL),
    .FALL      (FALL),
    .OFF_ENCLR (OFF_ENCLR),
    .OFF_ENSET (OFF_ENSET),
    .OFF_FLAG  (OFF_FLAG)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .status_i (status_i),
    .irq_o    (irq_o),
    .flag_q   (flag_q),
    .en_q     (en_q)
);

// File: tb/irq_flag_reg_test.sv
module irq_flag_reg_test;

    localparam int          CLK_T = 10;
    localparam logic [31:0] MASK  = 32'h000F_0713;
    localparam logic [7:0]  A_CLR = 8'h04;
    localparam logic [7:0]  A_SET = 8'h08;
    localparam logic [7:0]  A_FLG = 8'h0C;

    typedef struct packed {
        logic [31:0] pre;
        logic [31:0] post;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_0000, 32'h000F_0713, 32'h0007_0713},
        '{32'h000F_0713, 32'h0000_0000, 32'h0008_0000},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0007_0713},
        '{32'hFFFF_FFFF, 32'hFFF0_F8EC, 32'h0008_0000},
        '{32'h0000_0000, 32'h0000_0011, 32'h0000_0011},
        '{32'h0008_0101, 32'h0000_0202, 32'h0008_0202}
    };

    logic        clk;
    logic        rst;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] status;
    logic        irq;
    logic [31:0] d;

    int n_chk = 0;
    int n_bad = 0;

    irq_flag_reg uut (
        .clk_i    (clk),
        .rst_i    (rst),
        .addr_i   (addr),
        .wr_en_i  (we),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .status_i (status),
        .irq_o    (irq)
    );

    initial clk = 1'b0;
    always #(CLK_T / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        addr  = a;
        wdata = v;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
        wdata = '0;
    endtask

    initial begin
        #(CLK_T * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        addr   = '0;
        we     = 1'b0;
        wdata  = '0;
        status = 32'h0008_0001;
        tick(3);
        // R1: state under reset
        rd(A_FLG, d); check("R1 flags in reset", d, '0);
        rd(A_SET, d); check("R1 enables in reset", d, '0);
        check("R1 irq in reset", {31'b0, irq}, '0);
        rst = 1'b0;
        tick(2);
        // R11: bit 0 high through reset sets its flag, bit 19 does not
        rd(A_FLG, d); check("R11 level high at reset release", d, 32'h0000_0001);
        check("R1 irq after reset", {31'b0, irq}, '0);

        status = '0;
        tick(3);
        wr(A_FLG, 32'hFFFF_FFFF);
        rd(A_FLG, d); check("R5 clear all", d, '0);

        // R3 R4 R2: edge table
        for (int i = 0; i < 6; i++) begin
            status = VECS[i].pre;
            tick(3);
            wr(A_FLG, 32'hFFFF_FFFF);
            status = VECS[i].post;
            tick(2);
            rd(A_FLG, d);
            check($sformatf("R3/R4 table entry %0d", i), d, VECS[i].exp);
        end

        // R9 R2: enable registers
        wr(A_SET, 32'hFFFF_FFFF);
        rd(A_SET, d); check("R9 enable set readback", d, MASK);
        rd(A_CLR, d); check("R9 enable clear readback", d, MASK);
        wr(A_CLR, 32'h0000_0700);
        rd(A_SET, d); check("R9 partial enable clear", d, 32'h000F_0013);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_CLR, d); check("R9 all enables cleared", d, '0);
        rd(8'h10, d); check("R2 unmapped address", d, '0);
        rd(8'h00, d); check("R2 address zero", d, '0);

        // R5 R6 R8
        status = '0;
        tick(3);
        wr(A_FLG, 32'hFFFF_FFFF);
        status = 32'h0000_0013;
        tick(2);
        rd(A_FLG, d); check("R3 rising bits 0 1 4", d, 32'h0000_0013);
        wr(A_FLG, 32'h0000_0000);
        rd(A_FLG, d); check("R6 write zero keeps flags", d, 32'h0000_0013);
        wr(A_FLG, 32'h0000_0002);
        rd(A_FLG, d); check("R5 single bit clear", d, 32'h0000_0011);
        wr(A_FLG, 32'hFFFF_FFFF);
        tick(4);
        rd(A_FLG, d); check("R8 steady level no reset", d, '0);

        // R7: edge and clear in the same cycle
        status = 32'h0000_0113;
        tick(1);
        wr(A_FLG, 32'h0000_0100);
        rd(A_FLG, d); check("R7 set beats clear", d, 32'h0000_0100);

        // R10: interrupt gating and latency
        check("R10 irq without enable", {31'b0, irq}, '0);
        wr(A_SET, 32'h0000_0100);
        check("R10 irq one edge late", {31'b0, irq}, '0);
        tick(1);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        wr(A_FLG, 32'h0000_0100);
        check("R10 irq held one edge after clear", {31'b0, irq}, 32'h1);
        tick(1);
        check("R10 irq dropped", {31'b0, irq}, '0);
        status = 32'h0001_0113;
        tick(3);
        rd(A_FLG, d); check("R3 bit 16 rising", d, 32'h0001_0000);
        check("R10 disabled flag gives no irq", {31'b0, irq}, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule